// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the attenuation envelope of a single FM synthesis operator. The attenuation is 10 bits wide. A value of 0 is the loudest output and 1023 is silence. The envelope moves through four states: attack, decay, sustain and release. The level key input opens a note on its rising edge and closes it on its falling edge. The operator's register fields are inputs: an attack rate, a decay rate, a sustain level and a release rate. A key-scale offset is added to every rate.

A sample strobe drives the block's time base. Every third strobe is an envelope tick, and each tick advances a free-running envelope counter. Each effective rate maps to a counter shift and a step size. The level changes only on ticks where the counter's bits below that shift are all zero.

The block also handles the short-cuts that happen at key-on. A very fast attack jumps straight to full level. A key-on that finds the level already at 0 does not enter attack at all. Writing a sustain level below the present attenuation during decay ends the decay at once. On every key-on the block also sends a one-cycle restart pulse to the operator's phase accumulator.

Top module: `fm_env_gen`

## Requirements
- R1: After a synchronous active-low reset, `atten` is 1023, `env_state` is release (encoding: 0 attack, 1 decay, 2 sustain, 3 release), `phase_rst` is 0 and the stored sustain level is 0.
- R2: An envelope tick occurs on every third `smp_stb` pulse counted from reset. The level changes only in the cycle of a tick, and only if the envelope counter value at that tick (0 at the first tick, +1 per tick, 12 bits, wrapping) has zeros in all bits below the rate's shift.
- R3: A rising edge of `key_in` with an effective attack rate (32 + 2·`atk_rate`, or 0 when that field is 0, plus `ks_ofs`) below 94 and a nonzero `atten` enters attack. The level is unchanged in that cycle.
- R4: Every rising edge of `key_in` makes `phase_rst` 1 for exactly the following cycle.
- R5: A rising edge of `key_in` with an effective attack rate below 94 while `atten` is 0 skips attack. It goes to sustain if the sustain level is 0 and to decay otherwise.
- R6: A rising edge of `key_in` with an effective attack rate of 94 or more sets `atten` to 0 at once. It then enters sustain if the sustain level is 0 and decay otherwise.
- R7: Each attack update subtracts ceil((atten+1)·step/16). When the result would be 0 or less, `atten` becomes 0 and the state becomes sustain (sustain level 0) or decay.
- R8: Each decay update adds the step to `atten`. Once `atten` reaches the sustain level or passes it, the state becomes sustain, which holds the level. The sustain level is `sus_lvl`·32, except that field 15 gives 992.
- R9: A `sus_we` pulse loads a new sustain level. If the state is decay and `atten` is already at or above the new level, the state becomes sustain in that cycle and the level is held. Otherwise the state is unchanged.
- R10: A falling edge of `key_in` enters release from any state. Release adds the step on each update and saturates at 1023. The effective release rate is 34 + 4·`rel_rate` + `ks_ofs`.
- R11: An effective rate below 32 (attack or decay field 0, or the sustain state) never changes the level.
- R12: For an effective rate r (limited to 127) with n = r − 32: if n < 48, the shift is 11 − floor(n/4) and the step is 1. If 48 ≤ n < 64, the shift is 0 and the step is 2^(floor(n/4) − 12). If r ≥ 96, the shift is 0 and the step is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One pulse per output sample |
| key_in | input | 1 | Key level; rising edge = key-on, falling edge = key-off |
| atk_rate | input | 5 | Attack rate field |
| dec_rate | input | 5 | Decay rate field |
| sus_we | input | 1 | Load strobe for the sustain level field |
| sus_lvl | input | 4 | Sustain level field |
| rel_rate | input | 4 | Release rate field |
| ks_ofs | input | 5 | Key-scale offset added to every rate |
| atten | output | 10 | Current attenuation, 0 loudest |
| env_state | output | 2 | Current state (0 attack, 1 decay, 2 sustain, 3 release) |
| phase_rst | output | 1 | One-cycle phase restart pulse after key-on |

## Verification
The hardest situation to reach is a sustain-level write that arrives during decay while the attenuation has already climbed past the new level. The stimulus gets there in three steps. An instant attack first forces the level to 0 with a nonzero sustain level, so the operator lands in decay. A slow decay rate then lets the level creep up for a few hundred cycles. Two writes follow: a higher level that must leave decay running, then level 0, which must freeze the envelope. Attack skipping is reached the same way: an instant attack to 0, then key-off and a new key-on with the sample strobe held low, so no release update can move the level first.

// File: rtl/fm_env_pkg.sv
// Shared types and constants of the operator envelope generator.
// Assumes a 10-bit attenuation scale where 0 is full level.
package fm_env_pkg;

    localparam int ATT_W        = 10;
    localparam int ATT_MAX      = (1 << ATT_W) - 1;
    localparam int RATE_W       = 7;
    localparam int INSTANT_RATE = 94;
    localparam int SLOW_LIMIT   = 32;

    typedef enum logic [1:0] {
        ENV_ATT = 2'd0,
        ENV_DEC = 2'd1,
        ENV_SUS = 2'd2,
        ENV_REL = 2'd3
    } env_state_e;

    // Map the 4-bit sustain field onto the attenuation scale; the top code is special.
    function automatic logic [ATT_W-1:0] sus_level(input logic [3:0] fld);
        if (fld == 4'hF) return 10'd992;
        return {1'b0, fld, 5'b0};
    endfunction

endpackage

// File: rtl/fm_env_timer.sv
// Envelope time base: divides the sample strobe by TICKS_PER_STEP and counts
// the resulting ticks. Assumes stb_i is at most one pulse per cycle.
module fm_env_timer #(
    parameter int TICKS_PER_STEP = 3,
    parameter int CNT_W          = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int DIV_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_STEP - 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;

    // A tick is the strobe that completes a divider period.
    always_comb tick_o = stb_i && (div_q == DIV_LAST);

    // Advance the divider on strobes and the counter on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (stb_i) begin
            if (tick_o) begin
                div_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;

    generate
        if (TICKS_PER_STEP > 1) begin : g_gap
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/fm_env_rate.sv
// Maps an effective rate onto a counter shift and a per-update step.
// Rates below 32 give a zero step, so the level never moves.
module fm_env_rate
    import fm_env_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    output logic [3:0]        shift_o,
    output logic [3:0]        step_o
);
    logic [RATE_W-1:0] n;

    // Piecewise mapping from rate to shift and step.
    always_comb begin
        n       = rate_i - RATE_W'(SLOW_LIMIT);
        shift_o = 4'd11;
        step_o  = 4'd0;
        if (rate_i < RATE_W'(SLOW_LIMIT)) begin
            shift_o = 4'd11;
            step_o  = 4'd0;
        end else if (n < 7'd48) begin
            shift_o = 4'd11 - n[5:2];
            step_o  = 4'd1;
        end else if (n < 7'd64) begin
            shift_o = 4'd0;
            step_o  = 4'd1 << n[3:2];
        end else begin
            shift_o = 4'd0;
            step_o  = 4'd8;
        end
    end

endmodule

// File: rtl/fm_env_core.sv
// State machine and level arithmetic of one operator envelope.
// Assumes tick_i/cnt_i come from fm_env_timer; key_i is a level.
// Priority within a cycle: key edge, then sustain write, then envelope update.
module fm_env_core
    import fm_env_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             key_i,
    input  logic [4:0]       ar_i,
    input  logic [4:0]       dr_i,
    input  logic             sl_we_i,
    input  logic [3:0]       sl_i,
    input  logic [3:0]       rr_i,
    input  logic [4:0]       ksr_i,
    output logic [ATT_W-1:0] atten_o,
    output env_state_e       state_o,
    output logic             phase_rst_o
);
    env_state_e        state_q, state_d;
    logic [ATT_W-1:0]  vol_q, vol_d;
    logic [ATT_W-1:0]  sl_q, sl_new;
    logic              key_q, phase_rst_q;
    logic              key_on_evt, key_off_evt;
    logic [7:0]        ar_base, dr_base, rr_base, sel_base, ar_eff, rate_sum;
    logic [RATE_W-1:0] rate_w;
    logic [3:0]        shift_w, step_w;
    logic [CNT_W-1:0]  low_mask;
    logic              upd;
    logic [14:0]       att_prod;
    logic [10:0]       att_dec, add_sum;
    logic [ATT_W-1:0]  add_sat;
    env_state_e        after_top;

    // Key edges and the sustain level in force this cycle.
    always_comb begin
        key_on_evt  = key_i && !key_q;
        key_off_evt = !key_i && key_q;
        sl_new      = sl_we_i ? sus_level(sl_i) : sl_q;
        after_top   = (sl_new == '0) ? ENV_SUS : ENV_DEC;
    end

    // Effective rates for each state, plus the key-scale offset.
    always_comb begin
        ar_base  = (ar_i == 5'd0) ? 8'd0 : 8'd32 + {2'b0, ar_i, 1'b0};
        dr_base  = (dr_i == 5'd0) ? 8'd0 : 8'd32 + {2'b0, dr_i, 1'b0};
        rr_base  = 8'd34 + {2'b0, rr_i, 2'b0};
        ar_eff   = ar_base + {3'b0, ksr_i};
        case (state_q)
            ENV_ATT: sel_base = ar_base;
            ENV_DEC: sel_base = dr_base;
            ENV_REL: sel_base = rr_base;
            default: sel_base = 8'd0;
        endcase
        rate_sum = sel_base + {3'b0, ksr_i};
        rate_w   = rate_sum[7] ? 7'd127 : rate_sum[6:0];
    end

    fm_env_rate u_rate (
        .rate_i  (rate_w),
        .shift_o (shift_w),
        .step_o  (step_w)
    );

    // Update enable and the two level arithmetic paths.
    always_comb begin
        low_mask = ~({CNT_W{1'b1}} << shift_w);
        upd      = tick_i && ((cnt_i & low_mask) == '0);
        att_prod = ({5'b0, vol_q} + 15'd1) * {11'b0, step_w};
        att_dec  = 11'((att_prod + 15'd15) >> 4);
        add_sum  = {1'b0, vol_q} + {7'b0, step_w};
        add_sat  = add_sum[10] ? ATT_W'(ATT_MAX) : add_sum[ATT_W-1:0];
    end

    // Next state and level.
    always_comb begin
        state_d = state_q;
        vol_d   = vol_q;
        if (key_on_evt) begin
            if (ar_eff < 8'(INSTANT_RATE)) begin
                state_d = (vol_q != '0) ? ENV_ATT : after_top;
            end else begin
                vol_d   = '0;
                state_d = after_top;
            end
        end else if (key_off_evt) begin
            state_d = ENV_REL;
        end else if (sl_we_i && state_q == ENV_DEC && vol_q >= sl_new) begin
            state_d = ENV_SUS;
        end else if (upd && step_w != 4'd0) begin
            case (state_q)
                ENV_ATT: begin
                    if (att_dec >= {1'b0, vol_q}) begin
                        vol_d   = '0;
                        state_d = after_top;
                    end else begin
                        vol_d = vol_q - att_dec[ATT_W-1:0];
                    end
                end
                ENV_DEC: begin
                    vol_d = add_sat;
                    if (add_sat >= sl_new) state_d = ENV_SUS;
                end
                ENV_REL: vol_d = add_sat;
                default: vol_d = vol_q;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ENV_REL;
            vol_q       <= ATT_W'(ATT_MAX);
            sl_q        <= '0;
            key_q       <= 1'b0;
            phase_rst_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            vol_q       <= vol_d;
            sl_q        <= sl_new;
            key_q       <= key_i;
            phase_rst_q <= key_on_evt;
        end
    end

    assign atten_o     = vol_q;
    assign state_o     = state_q;
    assign phase_rst_o = phase_rst_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (vol_q == ATT_W'(ATT_MAX) && state_q == ENV_REL));
    // R4
    phase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_q |=> !phase_rst_q);
    // R4
    phase_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_q |-> state_q != ENV_REL);
    // R7
    attack_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENV_ATT && !key_on_evt) |=> vol_q <= $past(vol_q));
    // R10
    release_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENV_REL && !key_on_evt) |=> vol_q >= $past(vol_q));
    // R11
    slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_w < RATE_W'(SLOW_LIMIT) && !key_on_evt) |=> $stable(vol_q));
    // R9
    sus_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_we_i && key_i == key_q && state_q == ENV_DEC && vol_q >= sl_new)
        |=> (state_q == ENV_SUS && $stable(vol_q)));

endmodule

// File: rtl/fm_env_gen.sv
// Top of the operator envelope generator: time base plus envelope core.
// Assumes smp_stb pulses once per output sample; key_in is held per note.
module fm_env_gen
    import fm_env_pkg::*;
#(
    parameter int TICKS_PER_STEP = 3,
    parameter int CNT_W          = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       key_in,
    input  logic [4:0] atk_rate,
    input  logic [4:0] dec_rate,
    input  logic       sus_we,
    input  logic [3:0] sus_lvl,
    input  logic [3:0] rel_rate,
    input  logic [4:0] ks_ofs,
    output logic [9:0] atten,
    output logic [1:0] env_state,
    output logic       phase_rst
);
    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;
    env_state_e       st_w;

    fm_env_timer #(
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .CNT_W          (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (smp_stb),
        .tick_o (tick_w),
        .cnt_o  (cnt_w)
    );

    fm_env_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_w),
        .cnt_i       (cnt_w),
        .key_i       (key_in),
        .ar_i        (atk_rate),
        .dr_i        (dec_rate),
        .sl_we_i     (sus_we),
        .sl_i        (sus_lvl),
        .rr_i        (rel_rate),
        .ksr_i       (ks_ofs),
        .atten_o     (atten),
        .state_o     (st_w),
        .phase_rst_o (phase_rst)
    );

    assign env_state = st_w;

endmodule

// File: tb/sim_fm_env_gen.sv
`timescale 1ns/1ps
module sim_fm_env_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       key_in = 1'b0;
    logic [4:0] atk_rate = '0;
    logic [4:0] dec_rate = '0;
    logic       sus_we = 1'b0;
    logic [3:0] sus_lvl = '0;
    logic [3:0] rel_rate = '0;
    logic [4:0] ks_ofs = '0;
    logic [9:0] atten;
    logic [1:0] env_state;
    logic       phase_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_vol, m_st, m_prst, m_key, m_sl, m_div, m_cnt;

    always #2 clk = ~clk;

    fm_env_gen u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .key_in(key_in),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_we(sus_we),
        .sus_lvl(sus_lvl), .rel_rate(rel_rate), .ks_ofs(ks_ofs),
        .atten(atten), .env_state(env_state), .phase_rst(phase_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sl_of(input int f);
        return (f == 15) ? 992 : f * 32;
    endfunction

    function automatic string tag_of(input int st);
        case (st)
            0: return "R7 attack level R12";
            1: return "R8 decay level R12";
            2: return "R8 sustain hold R11";
            default: return "R10 release level R12";
        endcase
    endfunction

    // One clock of the reference model, using the inputs as driven now.
    task automatic model_edge();
        int tick, cnt_used, sl_new, kon, koff, base, r, n, sh, stp, upd, ar_eff, nxt_after, d;
        if (!rst_n) begin
            m_vol = 1023; m_st = 3; m_prst = 0; m_key = 0; m_sl = 0; m_div = 0; m_cnt = 0;
            return;
        end
        tick = (smp_stb && m_div == 2);
        cnt_used = m_cnt;
        if (smp_stb) begin
            if (tick) begin m_div = 0; m_cnt = (m_cnt + 1) % 4096; end
            else m_div = m_div + 1;
        end
        sl_new = sus_we ? sl_of(sus_lvl) : m_sl;
        nxt_after = (sl_new == 0) ? 2 : 1;
        kon  = (key_in && !m_key);
        koff = (!key_in && m_key);
        ar_eff = ((atk_rate == 0) ? 0 : 32 + 2 * atk_rate) + ks_ofs;
        case (m_st)
            0: base = (atk_rate == 0) ? 0 : 32 + 2 * atk_rate;
            1: base = (dec_rate == 0) ? 0 : 32 + 2 * dec_rate;
            3: base = 34 + 4 * rel_rate;
            default: base = 0;
        endcase
        r = base + ks_ofs;
        if (r > 127) r = 127;
        n = r - 32;
        if (r < 32) begin sh = 11; stp = 0; end
        else if (n < 48) begin sh = 11 - n / 4; stp = 1; end
        else if (n < 64) begin sh = 0; stp = 1 << (n / 4 - 12); end
        else begin sh = 0; stp = 8; end
        upd = tick && ((cnt_used % (1 << sh)) == 0);
        if (kon) begin
            if (ar_eff < 94) m_st = (m_vol != 0) ? 0 : nxt_after;
            else begin m_vol = 0; m_st = nxt_after; end
        end else if (koff) begin
            m_st = 3;
        end else if (sus_we && m_st == 1 && m_vol >= sl_new) begin
            m_st = 2;
        end else if (upd && stp != 0) begin
            if (m_st == 0) begin
                d = ((m_vol + 1) * stp + 15) / 16;
                if (d >= m_vol) begin m_vol = 0; m_st = nxt_after; end
                else m_vol = m_vol - d;
            end else if (m_st == 1) begin
                m_vol = (m_vol + stp > 1023) ? 1023 : m_vol + stp;
                if (m_vol >= sl_new) m_st = 2;
            end else if (m_st == 3) begin
                m_vol = (m_vol + stp > 1023) ? 1023 : m_vol + stp;
            end
        end
        m_prst = kon;
        m_key = key_in;
        m_sl = sl_new;
    endtask

    // Advance one clock and compare every output with the model.
    task automatic step();
        model_edge();
        @(negedge clk);
        check(tag_of(m_st), int'(atten), m_vol);
        check("R1 R3 R5 R6 R9 R10 state", int'(env_state), m_st);
        check("R4 phase restart", int'(phase_rst), m_prst);
    endtask

    task automatic run(input int cyc, input int stb_every);
        int prev;
        for (int i = 0; i < cyc; i++) begin
            prev = int'(env_state);
            smp_stb = (stb_every > 0) && (i % stb_every != 0 || stb_every == 1);
            step();
            if (prev == 0 && int'(env_state) != 0 && key_in) begin
                check("R7 attack end level", int'(atten), 0);
                check("R7 attack end state", int'(env_state), (m_sl == 0) ? 2 : 1);
            end
        end
        smp_stb = 1'b0;
    endtask

    task automatic write_sl(input int f);
        sus_we = 1'b1; sus_lvl = 4'(f);
        step();
        sus_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        step();
        check("R1 reset atten", int'(atten), 1023);
        check("R1 reset state", int'(env_state), 3);
        check("R1 reset phase", int'(phase_rst), 0);

        // instant attack, phase pulse
        atk_rate = 5'd31; ks_ofs = 5'd0; key_in = 1'b1;
        step();
        check("R6 instant atten", int'(atten), 0);
        check("R6 instant state", int'(env_state), 2);
        check("R4 pulse high", int'(phase_rst), 1);
        step();
        check("R4 pulse low", int'(phase_rst), 0);
        key_in = 1'b0;
        step();
        check("R10 key-off state", int'(env_state), 3);

        // tick on every third strobe
        rel_rate = 4'd15; ks_ofs = 5'd31;
        smp_stb = 1'b1; step(); smp_stb = 1'b0;
        check("R2 strobe 1", int'(atten), 0);
        smp_stb = 1'b1; step(); smp_stb = 1'b0;
        check("R2 strobe 2", int'(atten), 0);
        smp_stb = 1'b1; step(); smp_stb = 1'b0;
        check("R2 strobe 3 tick", int'(atten), 8);

        run(450, 1);
        check("R10 release saturates", int'(atten), 1023);

        // normal attack then decay to sustain level 160
        atk_rate = 5'd10; dec_rate = 5'd8; ks_ofs = 5'd20;
        write_sl(5);
        key_in = 1'b1;
        step();
        check("R3 attack entered", int'(env_state), 0);
        check("R3 level kept", int'(atten), 1023);
        run(6000, 1);
        check("R8 sustain level", int'(atten), 160);
        check("R8 sustain state", int'(env_state), 2);

        // sustain write during decay
        key_in = 1'b0; rel_rate = 4'd15; ks_ofs = 5'd31;
        run(450, 1);
        atk_rate = 5'd31; dec_rate = 5'd4; ks_ofs = 5'd20;
        sus_we = 1'b1; sus_lvl = 4'd10; key_in = 1'b1;
        step();
        sus_we = 1'b0;
        check("R6 instant to decay", int'(env_state), 1);
        run(600, 1);
        write_sl(15);
        check("R9 higher level keeps decay", int'(env_state), 1);
        write_sl(0);
        check("R9 forced sustain", int'(env_state), 2);
        run(300, 1);

        // skipped attack at level 0 (no strobes, so no updates)
        key_in = 1'b0; step();
        atk_rate = 5'd31; key_in = 1'b1; step();
        key_in = 1'b0; step();
        atk_rate = 5'd10; ks_ofs = 5'd0; key_in = 1'b1;
        step();
        check("R5 skip to sustain", int'(env_state), 2);
        check("R5 level zero", int'(atten), 0);
        key_in = 1'b0; step();
        write_sl(3);
        key_in = 1'b1;
        step();
        check("R5 skip to decay", int'(env_state), 1);

        // slow region never moves
        key_in = 1'b0; rel_rate = 4'd15; ks_ofs = 5'd31;
        run(450, 1);
        atk_rate = 5'd0; key_in = 1'b1;
        step();
        run(3000, 1);
        check("R11 slow attack level", int'(atten), 1023);
        check("R11 slow attack state", int'(env_state), 0);

        // irregular strobes through attack and release
        atk_rate = 5'd12; ks_ofs = 5'd10; key_in = 1'b0; step();
        key_in = 1'b1;
        run(3000, 5);
        key_in = 1'b0; rel_rate = 4'd3;
        run(3000, 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule